// File: doc/BRIEF.md
# Panel Power Sequencer

This block walks a small TFT panel from deep standby to display-on and back to sleep. It drives a separate serial command writer. For each step it presents a command byte, a payload length of zero, one or two bytes, and a 16-bit payload. It then waits for the writer's done pulse before it moves to the next step. The steps are held in a small synchronous ROM. Each entry carries the command, the length, the payload and three flags: hold for a millisecond delay, check for an abort, and last step.

A one-cycle `up_req` pulse starts power-up and a one-cycle `down_req` pulse starts power-down. Millisecond delays are counted on the external `ms_tick` strobe, so a simulation can use a short tick period.

`panel_active` reports whether the panel is on. `io_error` reports whether the last power-up failed. `busy` covers the whole run of a sequence.

Top module: `pps_ctrl`

## Requirements
- R1: After reset, `busy`, `panel_active`, `io_error` and `cw_req` are all 0.
- R2: Power-up opens with three requests for command 0x00 with `cw_nbytes` = 0.
- R3: After the done of each opening 0x00 command, the block waits for `HOLD_TICKS` (default 2) `ms_tick` pulses before it issues the next request. A tick in the done cycle itself does not count, so the wait lies between 1 ms and 2 ms.
- R4: If any of the three opening commands returns `cw_err`, the sequence stops after the third one. `panel_active` stays 0 and `io_error` becomes 1.
- R5: Power-up continues with the steps below, in this order. Each step is written as command, length, payload, and the payload is right-aligned in `cw_payload`. The steps are:
  - B0, 1, 0x0017
  - BC, 1, 0x0080
  - 3B, 1, 0x0000
  - B0, 1, 0x0016
  - B8, 2, 0xFFF9
  - 11, 0
  - 29, 0
- R6: `panel_active` rises only after the done of the final 0x29 step. An error on any step after the opening three does not stop the sequence, but it sets `io_error` to 1 when the sequence ends; the panel still becomes active.
- R7: Power-down issues four steps, in this order:
  - 28, 0
  - B8, 2, 0x8002
  - 10, 0
  - B0, 1, 0x0000

  After the fourth step `panel_active` becomes 0. Errors during power-down are not reported, and `io_error` reads 0 afterwards.
- R8: `up_req` while the panel is active, and `down_req` while it is disabled, start no requests and leave `busy` at 0.
- R9: `busy` goes high in the cycle after an accepted request and stays high until the sequence ends. Requests that arrive while `busy` is high are ignored.
- R10: `cw_req` is a one-cycle pulse. At most one request is outstanding, and the next request is issued only after `cw_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Power-up request pulse |
| down_req | input | 1 | Power-down request pulse |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| cw_req | output | 1 | Command writer request pulse |
| cw_cmd | output | 8 | Command byte |
| cw_nbytes | output | 2 | Payload byte count (0, 1 or 2) |
| cw_payload | output | 16 | Payload, right-aligned |
| cw_done | input | 1 | Writer finished the current command |
| cw_err | input | 1 | Writer reports failure; valid with cw_done |
| busy | output | 1 | Sequence in progress |
| panel_active | output | 1 | Panel is in the display-on state |
| io_error | output | 1 | Last power-up saw a failed write |

## Verification
The assertions take for granted that `cw_done` comes only in reply to a request, as a single-cycle pulse held for one clock. They also take for granted that `cw_err` is meaningful only alongside it. The bench's command writer model answers each request exactly once, after a fixed latency. The tick strobe runs at a period longer than the three cycles between the end of a hold and the next issue, so every hold measures exactly the programmed tick count. The sweep injects a writer error at every step position, including none, and uses each resulting active state to drive a power-down with its own error.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int CMD_W = 8;
  localparam int PAY_W = 16;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic [1:0]       nbytes;
    logic [PAY_W-1:0] payload;
    logic             hold_ms;  // wait on the millisecond strobe after done
    logic             gate;     // abort point for early errors
    logic             last;     // final step of its sequence
  } seq_entry_t;

  // Entry points into the step ROM
  localparam int UP_START = 0;
  localparam int DN_START = 10;
  localparam int N_STEPS  = 14;
endpackage

// File: rtl/pps_seq_rom.sv
module pps_seq_rom
  import pps_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  output seq_entry_t       entry
);
  function automatic seq_entry_t step(input logic [IDX_W-1:0] a);
    seq_entry_t e;
    e = '0;
    case (a)
      // power-up: three bare null commands with a hold after each
      4'd0:  e = '{8'h00, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b0};
      4'd1:  e = '{8'h00, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b0};
      4'd2:  e = '{8'h00, 2'd0, 16'h0000, 1'b1, 1'b1, 1'b0};
      4'd3:  e = '{8'hB0, 2'd1, 16'h0017, 1'b0, 1'b0, 1'b0};
      4'd4:  e = '{8'hBC, 2'd1, 16'h0080, 1'b0, 1'b0, 1'b0};
      4'd5:  e = '{8'h3B, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b0};
      4'd6:  e = '{8'hB0, 2'd1, 16'h0016, 1'b0, 1'b0, 1'b0};
      4'd7:  e = '{8'hB8, 2'd2, 16'hFFF9, 1'b0, 1'b0, 1'b0};
      4'd8:  e = '{8'h11, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0};
      4'd9:  e = '{8'h29, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1};
      // power-down
      4'd10: e = '{8'h28, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0};
      4'd11: e = '{8'hB8, 2'd2, 16'h8002, 1'b0, 1'b0, 1'b0};
      4'd12: e = '{8'h10, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0};
      4'd13: e = '{8'hB0, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b1};
      default: e = '{8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1};
    endcase
    return e;
  endfunction

  // Registered read so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    entry <= step(addr);
  end
endmodule

// File: rtl/pps_ms_wait.sv
module pps_ms_wait #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assign expired = run && tick && (cnt == CW'(TICKS - 1));
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int HOLD_TICKS = 2,
  parameter int IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              down_req,
  input  logic              ms_tick,
  output logic              cw_req,
  output logic [CMD_W-1:0]  cw_cmd,
  output logic [1:0]        cw_nbytes,
  output logic [PAY_W-1:0]  cw_payload,
  input  logic              cw_done,
  input  logic              cw_err,
  output logic              busy,
  output logic              panel_active,
  output logic              io_error
);
  localparam logic [IDX_W-1:0] UP_IDX = IDX_W'(UP_START);
  localparam logic [IDX_W-1:0] DN_IDX = IDX_W'(DN_START);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_HOLD, S_STEP} st_t;

  st_t             state;
  logic [IDX_W-1:0] idx;
  logic            going_up;
  logic            err_acc;
  logic            hold_over;
  seq_entry_t      ent;

  pps_seq_rom #(.IDX_W(IDX_W)) u_rom (
    .clk   (clk),
    .addr  (idx),
    .entry (ent)
  );

  pps_ms_wait #(.TICKS(HOLD_TICKS)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .run     (state == S_HOLD),
    .tick    (ms_tick),
    .expired (hold_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      idx          <= '0;
      going_up     <= 1'b0;
      err_acc      <= 1'b0;
      cw_req       <= 1'b0;
      cw_cmd       <= '0;
      cw_nbytes    <= '0;
      cw_payload   <= '0;
      busy         <= 1'b0;
      panel_active <= 1'b0;
      io_error     <= 1'b0;
    end else begin
      cw_req <= 1'b0;
      case (state)
        S_IDLE: begin
          if (up_req && !panel_active) begin
            idx <= UP_IDX; going_up <= 1'b1; err_acc <= 1'b0;
            io_error <= 1'b0; busy <= 1'b1; state <= S_FETCH;
          end else if (down_req && panel_active) begin
            idx <= DN_IDX; going_up <= 1'b0; err_acc <= 1'b0;
            io_error <= 1'b0; busy <= 1'b1; state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_ISSUE;
        S_ISSUE: begin
          cw_req     <= 1'b1;
          cw_cmd     <= ent.cmd;
          cw_nbytes  <= ent.nbytes;
          cw_payload <= ent.payload;
          state      <= S_WAIT;
        end
        S_WAIT: begin
          if (cw_done) begin
            if (cw_err && going_up) err_acc <= 1'b1;
            state <= ent.hold_ms ? S_HOLD : S_STEP;
          end
        end
        S_HOLD: if (hold_over) state <= S_STEP;
        S_STEP: begin
          if (ent.last) begin
            panel_active <= going_up;
            if (going_up) io_error <= err_acc;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (ent.gate && err_acc) begin
            io_error <= 1'b1;
            busy     <= 1'b0;
            state    <= S_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: a request is a single-cycle pulse
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
    cw_req |=> !cw_req);

  // R9: no request leaves the block while it reports idle
  a_r9_no_req_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cw_req);

  // R6: the panel turns on only two cycles after a writer done
  a_r6_active_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(panel_active) |-> $past(cw_done, 2));

  // R7: the panel state moves only as a sequence ends
  a_r7_state_at_end: assert property (@(posedge clk) disable iff (rst)
    (panel_active != $past(panel_active)) |-> ($fell(busy) || !busy));

  // R10: a writer done while a request is being issued is not expected
  a_r10_done_not_with_req: assert property (@(posedge clk) disable iff (rst)
    cw_req |-> !cw_done);
endmodule

// File: tb/sim_pps_ctrl.sv
module sim_pps_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic        up_req = 0, down_req = 0, ms_tick = 0;
  logic        cw_req;
  logic [7:0]  cw_cmd;
  logic [1:0]  cw_nbytes;
  logic [15:0] cw_payload;
  logic        cw_done = 0, cw_err = 0;
  logic        busy, panel_active, io_error;

  localparam int LAT  = 3;
  localparam int TPER = 7;
  localparam int HOLD = 2;

  int tests = 0, fails = 0, cycles = 0;
  int n_log = 0, err_pos = -1, wait_cnt = 0, tick_ph = 0, tcnt = 0;
  bit pend_err = 0;
  logic [7:0]  cmd_log [0:15];
  logic [1:0]  len_log [0:15];
  logic [15:0] pay_log [0:15];
  int          tck_log [0:15];

  always #10 clk = ~clk;  // 50 MHz

  pps_ctrl u0 (
    .clk(clk), .rst(rst), .up_req(up_req), .down_req(down_req), .ms_tick(ms_tick),
    .cw_req(cw_req), .cw_cmd(cw_cmd), .cw_nbytes(cw_nbytes), .cw_payload(cw_payload),
    .cw_done(cw_done), .cw_err(cw_err), .busy(busy), .panel_active(panel_active),
    .io_error(io_error)
  );

  // ticks seen after the most recent writer done
  always @(posedge clk) begin
    if (cw_done) tcnt <= 0;
    else if (ms_tick) tcnt <= tcnt + 1;
  end

  // command writer model and tick strobe
  always @(negedge clk) begin
    cycles++;
    cw_done = 0; cw_err = 0;
    if (cw_req) begin
      if (n_log < 16) begin
        cmd_log[n_log] = cw_cmd; len_log[n_log] = cw_nbytes;
        pay_log[n_log] = cw_payload; tck_log[n_log] = tcnt;
      end
      pend_err = (n_log == err_pos);
      n_log++;
      wait_cnt = LAT;
    end else if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin cw_done = 1; cw_err = pend_err; end
    end
    tick_ph = (tick_ph + 1) % TPER;
    ms_tick = (tick_ph == 0);
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] up_cmd(input int i);
    case (i)
      3: return 8'hB0; 4: return 8'hBC; 5: return 8'h3B; 6: return 8'hB0;
      7: return 8'hB8; 8: return 8'h11; 9: return 8'h29; default: return 8'h00;
    endcase
  endfunction
  function automatic int up_len(input int i);
    if (i >= 3 && i <= 6) return 1;
    if (i == 7) return 2;
    return 0;
  endfunction
  function automatic int up_pay(input int i);
    case (i)
      3: return 'h17; 4: return 'h80; 6: return 'h16; 7: return 'hFFF9; default: return 0;
    endcase
  endfunction
  function automatic logic [7:0] dn_cmd(input int i);
    case (i) 0: return 8'h28; 1: return 8'hB8; 2: return 8'h10; default: return 8'hB0; endcase
  endfunction
  function automatic int dn_len(input int i);
    case (i) 1: return 2; 3: return 1; default: return 0; endcase
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_up(input int e, input bit poke);
    int exp_n;
    n_log = 0; err_pos = e;
    up_req = 1; @(negedge clk); up_req = 0;
    chk(busy == 1, "R9 busy after up request", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      down_req = 1; up_req = 1; @(negedge clk); down_req = 0; up_req = 0;
    end
    wait_idle();
    exp_n = (e >= 0 && e <= 2) ? 3 : 10;
    chk(n_log == exp_n, "R4/R5 request count", n_log, exp_n);
    for (int i = 0; i < exp_n && i < n_log; i++) begin
      if (i < 3) chk(cmd_log[i] == 8'h00 && len_log[i] == 0, "R2 null command", cmd_log[i], 0);
      else begin
        chk(cmd_log[i] == up_cmd(i), "R5 command order", cmd_log[i], up_cmd(i));
        chk(len_log[i] == up_len(i), "R5 length", len_log[i], up_len(i));
        if (up_len(i) > 0) chk(pay_log[i] == up_pay(i), "R5 payload", pay_log[i], up_pay(i));
      end
      if (i >= 1 && i <= 3) chk(tck_log[i] == HOLD, "R3 hold ticks", tck_log[i], HOLD);
    end
    if (exp_n == 3) begin
      chk(panel_active == 0, "R4 stays disabled", panel_active, 0);
      chk(io_error == 1, "R4 io_error", io_error, 1);
    end else begin
      chk(panel_active == 1, "R6 active", panel_active, 1);
      chk(io_error == (e >= 3), "R6 collected error", io_error, (e >= 3));
    end
  endtask

  task automatic run_down(input int e);
    n_log = 0; err_pos = e;
    down_req = 1; @(negedge clk); down_req = 0;
    wait_idle();
    chk(n_log == 4, "R7 request count", n_log, 4);
    for (int i = 0; i < 4 && i < n_log; i++) begin
      chk(cmd_log[i] == dn_cmd(i), "R7 command order", cmd_log[i], dn_cmd(i));
      chk(len_log[i] == dn_len(i), "R7 length", len_log[i], dn_len(i));
    end
    chk(pay_log[1] == 16'h8002 && pay_log[3] == 16'h0000, "R7 payloads", pay_log[1], 16'h8002);
    chk(panel_active == 0, "R7 disabled", panel_active, 0);
    chk(io_error == 0, "R7 errors not reported", io_error, 0);
  endtask

  task automatic idle_probe(input bit up, input int exp_act);
    n_log = 0;
    if (up) up_req = 1; else down_req = 1;
    @(negedge clk); up_req = 0; down_req = 0;
    chk(busy == 0, "R8 no busy on redundant request", busy, 0);
    repeat (10) @(negedge clk);
    chk(n_log == 0, "R8 no requests issued", n_log, 0);
    chk(panel_active == exp_act, "R8 state unchanged", panel_active, exp_act);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && cw_req == 0, "R1 reset idle", busy, 0);
    chk(panel_active == 0 && io_error == 0, "R1 reset status", panel_active, 0);
    idle_probe(0, 0);
    for (int e = -1; e <= 9; e++) begin
      run_up(e, (e == 5 || e == -1));
      if (panel_active) begin
        idle_probe(1, 1);
        run_down((e + 4) % 4);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule